// File: doc/BRIEF.md
# Floating-Point Status Register with Compare Queue

This block holds the 32-bit status and control word that sits beside a floating-point datapath. After each datapath operation it folds the operation's raw exception flags into sticky bits. It requests a trap when a flag raised by that operation meets an enabled trap bit. When the operation is a compare, it records the outcome in one of two ways: in a condition bit chosen by the compare, or by pushing it into a shifting queue of earlier compare results. The block also decodes the rounding mode and the flush-to-zero control that the datapath needs. Software can replace the whole word with a single load.

Each operation completes in a single cycle. A load, a plain operation, a compare operation or an idle cycle is classified into one of four update kinds: `UPD_LOAD`, `UPD_ACCUM`, `UPD_COMPARE` and `UPD_HOLD`. The trap output comes from a two-state machine. `TRAP_IDLE` moves to `TRAP_FIRE` on a trapping operation. `TRAP_FIRE` returns to `TRAP_IDLE` on the next edge unless another trapping operation arrives, in which case it stays in `TRAP_FIRE`.

Top module: `fpsr_ctrl`

## Requirements
- R1: After reset, `status_q` is 0, `trap_req` is 0, `round_mode` is 0 and `flush_en` is 0.
- R2: When `load_en` is high at a clock edge, `status_q` takes `load_value` in full after that edge.
- R3: `round_mode` equals `status_q[10:9]`, encoded 0 = nearest even, 1 = toward zero, 2 = toward plus infinity, 3 = toward minus infinity. `flush_en` equals `status_q[5]`.
- R4: On `op_done`, the flags (`op_flags` bit 0 inexact, 1 underflow, 2 overflow, 3 divide-by-zero, 4 invalid) are ORed into `status_q[31:27]`, with flag i going to bit 27+i. These bits stay set until a load.
- R5: A non-compare operation with no flags raised leaves `status_q` unchanged, and so does a cycle with neither `op_done` nor `load_en`.
- R6: In the cycle after an operation, `trap_req` is high for one cycle when `op_flags & status_q[4:0]` is nonzero, where enable bit i matches flag i. This holds even if the flag was already sticky. `trap_req` is low otherwise.
- R7: For a compare, the recorded outcome is one bit of `cmp_cond`. `cmp_result` 0 (greater) selects bit 4, 1 (less) selects bit 3, 2 (equal) selects bit 2 and 3 (unordered) selects bit 1.
- R8: A compare with `cmp_target` y ≠ 0 writes the outcome to `status_q[22-y]` and changes no other bit apart from the sticky flags.
- R9: A compare with `cmp_target` 0 moves old bits 21:12 into bits 20:11, moves old bit 26 into bit 21, and writes the outcome to bit 26.
- R10: A load and an operation in the same cycle: the load wins, the operation has no effect and no trap follows.
- R11: Flags and a compare in the same operation are both applied. The accumulation is applied first and the compare update is applied on top of it.
- R12: `cmp_signaling` follows `cmp_cond[0]` combinationally, marking a signaling compare for the datapath.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_en | input | 1 | Replace the whole register |
| load_value | input | 32 | Value for a load |
| op_done | input | 1 | Datapath operation completed this cycle |
| op_flags | input | 5 | Raw exception flags of the operation |
| op_is_cmp | input | 1 | The completed operation is a compare |
| cmp_result | input | 2 | Compare relation: 0 gt, 1 lt, 2 eq, 3 unordered |
| cmp_cond | input | 5 | Condition mask; bits 4:1 per relation, bit 0 signaling |
| cmp_target | input | 3 | Target condition index; 0 pushes into the queue |
| status_q | output | 32 | Current register value |
| round_mode | output | 2 | Decoded rounding mode |
| flush_en | output | 1 | Flush denormals to zero |
| trap_req | output | 1 | Trap request pulse |
| cmp_signaling | output | 1 | Signaling compare selected |

## Verification
The hardest situation to reach from the ports is a queue push that lands on a register already full of history. The shift is only visible when old bits 26 and 21:12 hold distinct, nonzero values. The bench therefore loads a chosen queue pattern first and then pushes several compares with alternating outcomes, checking the whole word after each push. A trap on a flag that is already sticky, and a load that collides with a trapping operation, are each set up with a load of the enable bits immediately before the operation.

// File: rtl/fpsr_pkg.sv
package fpsr_pkg;
    localparam int REG_W      = 32;
    localparam int FLAG_W     = 5;
    localparam int STICKY_LSB = 27;
    localparam int ENABLE_LSB = 0;
    localparam int RM_LSB     = 9;
    localparam int FTZ_BIT    = 5;
    localparam int CBIT       = 26;
    localparam int QUEUE_MSB  = 21;
    localparam int QUEUE_LEN  = 10;
    localparam int TGT_W      = 3;
    localparam int SEL_W      = 4;

    typedef enum logic [1:0] {REL_GT, REL_LT, REL_EQ, REL_UN} rel_e;
    typedef enum logic [1:0] {RND_NEAREST, RND_ZERO, RND_PLUS, RND_MINUS} rnd_e;
    typedef enum logic [1:0] {UPD_HOLD, UPD_LOAD, UPD_ACCUM, UPD_COMPARE} upd_e;
    typedef enum logic {TRAP_IDLE, TRAP_FIRE} trap_st_e;
endpackage

// File: rtl/fpsr_exc_merge.sv
module fpsr_exc_merge
    import fpsr_pkg::*;
#(
    parameter int W   = REG_W,
    parameter int NF  = FLAG_W,
    parameter int SLB = STICKY_LSB,
    parameter int ELB = ENABLE_LSB
) (
    input  logic [W-1:0]  cur,
    input  logic [NF-1:0] flags,
    output logic [W-1:0]  merged,
    output logic          trap_hit
);
    logic [NF-1:0] hit_vec;

    for (genvar i = 0; i < NF; i++) begin : g_flag
        assign hit_vec[i] = flags[i] & cur[ELB+i];
    end

    always_comb begin
        merged = cur;
        for (int k = 0; k < NF; k++) begin
            merged[SLB+k] = cur[SLB+k] | flags[k];
        end
    end

    assign trap_hit = |hit_vec;
endmodule

// File: rtl/fpsr_cmp_update.sv
module fpsr_cmp_update
    import fpsr_pkg::*;
#(
    parameter int W    = REG_W,
    parameter int TW   = TGT_W,
    parameter int QMSB = QUEUE_MSB,
    parameter int QLEN = QUEUE_LEN,
    parameter int CB   = CBIT
) (
    input  logic [W-1:0]     base,
    input  rel_e             rel,
    input  logic [SEL_W-1:0] sel_mask,
    input  logic [TW-1:0]    target,
    output logic [W-1:0]     next_val
);
    logic outcome;

    always_comb begin
        unique case (rel)
            REL_GT:  outcome = sel_mask[3];
            REL_LT:  outcome = sel_mask[2];
            REL_EQ:  outcome = sel_mask[1];
            REL_UN:  outcome = sel_mask[0];
            default: outcome = 1'b0;
        endcase
    end

    always_comb begin
        next_val = base;
        if (target != '0) begin
            next_val[QMSB + 1 - int'(target)] = outcome;
        end else begin
            for (int k = 0; k < QLEN; k++) begin
                next_val[QMSB-1-k] = base[QMSB-k];
            end
            next_val[QMSB] = base[CB];
            next_val[CB]   = outcome;
        end
    end

    always_comb begin
        a_r8_target_in_queue: assert ((1 << TW) - 1 <= QLEN);
    end
endmodule

// File: rtl/fpsr_mode_decode.sv
module fpsr_mode_decode
    import fpsr_pkg::*;
(
    input  logic [1:0] rm_field,
    input  logic       ftz_bit,
    output rnd_e       rnd,
    output logic       ftz
);
    always_comb begin
        unique case (rm_field)
            2'd0:    rnd = RND_NEAREST;
            2'd1:    rnd = RND_ZERO;
            2'd2:    rnd = RND_PLUS;
            2'd3:    rnd = RND_MINUS;
            default: rnd = RND_NEAREST;
        endcase
    end

    assign ftz = ftz_bit;
endmodule

// File: rtl/fpsr_ctrl.sv
module fpsr_ctrl
    import fpsr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [31:0]       load_value,
    input  logic              op_done,
    input  logic [4:0]        op_flags,
    input  logic              op_is_cmp,
    input  logic [1:0]        cmp_result,
    input  logic [4:0]        cmp_cond,
    input  logic [2:0]        cmp_target,
    output logic [31:0]       status_q,
    output logic [1:0]        round_mode,
    output logic              flush_en,
    output logic              trap_req,
    output logic              cmp_signaling
);
    upd_e          upd_kind;
    trap_st_e      trap_st;
    trap_st_e      trap_nx;
    logic [31:0]   status_d;
    logic [31:0]   merged;
    logic [31:0]   cmp_next;
    logic          trap_hit;
    rnd_e          rnd;

    fpsr_exc_merge u_merge (
        .cur      (status_q),
        .flags    (op_flags),
        .merged   (merged),
        .trap_hit (trap_hit)
    );

    fpsr_cmp_update u_cmp (
        .base     (merged),
        .rel      (rel_e'(cmp_result)),
        .sel_mask (cmp_cond[4:1]),
        .target   (cmp_target),
        .next_val (cmp_next)
    );

    fpsr_mode_decode u_mode (
        .rm_field (status_q[RM_LSB+1:RM_LSB]),
        .ftz_bit  (status_q[FTZ_BIT]),
        .rnd      (rnd),
        .ftz      (flush_en)
    );

    always_comb begin
        if (load_en)                upd_kind = UPD_LOAD;
        else if (op_done && op_is_cmp) upd_kind = UPD_COMPARE;
        else if (op_done)           upd_kind = UPD_ACCUM;
        else                        upd_kind = UPD_HOLD;
    end

    always_comb begin
        unique case (upd_kind)
            UPD_LOAD:    status_d = load_value;
            UPD_ACCUM:   status_d = merged;
            UPD_COMPARE: status_d = cmp_next;
            default:     status_d = status_q;
        endcase
    end

    always_comb begin
        unique case (upd_kind)
            UPD_ACCUM, UPD_COMPARE: trap_nx = trap_hit ? TRAP_FIRE : TRAP_IDLE;
            default:                trap_nx = TRAP_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= '0;
            trap_st  <= TRAP_IDLE;
        end else begin
            status_q <= status_d;
            trap_st  <= trap_nx;
        end
    end

    always_comb begin
        unique case (trap_st)
            TRAP_FIRE: trap_req = 1'b1;
            default:   trap_req = 1'b0;
        endcase
    end

    assign round_mode    = rnd;
    assign cmp_signaling = cmp_cond[0];

    a_r2_load_replaces: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> status_q == $past(load_value));

    a_r4_sticky_kept: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en |=> ((status_q[31:27] & $past(status_q[31:27])) == $past(status_q[31:27])));

    a_r5_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && !op_done) |=> $stable(status_q));

    a_r6_trap_cause: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> ($past(op_done) && !$past(load_en)
                      && ($past(op_flags & status_q[4:0]) != 5'd0)));

    a_r10_load_no_trap: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> !trap_req);
endmodule

// File: tb/fpsr_ctrl_bench.sv
module fpsr_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_en = 1'b0;
    logic [31:0] load_value = '0;
    logic        op_done = 1'b0;
    logic [4:0]  op_flags = '0;
    logic        op_is_cmp = 1'b0;
    logic [1:0]  cmp_result = '0;
    logic [4:0]  cmp_cond = '0;
    logic [2:0]  cmp_target = '0;
    logic [31:0] status_q;
    logic [1:0]  round_mode;
    logic        flush_en;
    logic        trap_req;
    logic        cmp_signaling;

    int total = 0;
    int bad = 0;
    logic [31:0] exp_s = '0;
    logic        exp_trap = 1'b0;
    bit          finished = 1'b0;

    always #5 clk = ~clk;

    fpsr_ctrl u_fpsr_ctrl (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_value(load_value),
        .op_done(op_done), .op_flags(op_flags), .op_is_cmp(op_is_cmp),
        .cmp_result(cmp_result), .cmp_cond(cmp_cond), .cmp_target(cmp_target),
        .status_q(status_q), .round_mode(round_mode), .flush_en(flush_en),
        .trap_req(trap_req), .cmp_signaling(cmp_signaling)
    );

    task automatic check(string req, logic [31:0] got, logic [31:0] want);
        total++;
        if (got !== want) begin
            bad++;
            $display("FAIL %s: got %h expected %h", req, got, want);
        end
    endtask

    function automatic logic [31:0] model_cmp(logic [31:0] s, logic [1:0] rel,
                                              logic [4:0] cond, logic [2:0] tgt);
        logic        c;
        logic [31:0] r;
        c = cond[4 - rel];
        r = s;
        if (tgt != 0) begin
            r[22 - tgt] = c;
        end else begin
            r[20:11] = s[21:12];
            r[21]    = s[26];
            r[26]    = c;
        end
        return r;
    endfunction

    task automatic do_load(logic [31:0] v);
        @(negedge clk);
        load_en = 1'b1;
        load_value = v;
        @(posedge clk);
        #1;
        load_en = 1'b0;
        exp_s = v;
    endtask

    task automatic do_op(string req, logic [4:0] fl, logic is_cmp, logic [1:0] rel,
                         logic [4:0] cond, logic [2:0] tgt);
        @(negedge clk);
        op_done = 1'b1;
        op_flags = fl;
        op_is_cmp = is_cmp;
        cmp_result = rel;
        cmp_cond = cond;
        cmp_target = tgt;
        exp_trap = |(fl & exp_s[4:0]);
        exp_s[31:27] = exp_s[31:27] | fl;
        if (is_cmp) exp_s = model_cmp(exp_s, rel, cond, tgt);
        @(posedge clk);
        #1;
        op_done = 1'b0;
        op_flags = '0;
        op_is_cmp = 1'b0;
        check(req, status_q, exp_s);
        check({req, " trap"}, {31'd0, trap_req}, {31'd0, exp_trap});
    endtask

    task automatic t_reset();
        check("R1 status", status_q, 32'd0);
        check("R1 trap", {31'd0, trap_req}, 32'd0);
        check("R1 round", {30'd0, round_mode}, 32'd0);
        check("R1 flush", {31'd0, flush_en}, 32'd0);
    endtask

    task automatic t_load_decode();
        for (int m = 0; m < 4; m++) begin
            logic [31:0] v;
            v = 32'h1234_0000 | (32'(m) << 9) | ((m % 2 == 1) ? 32'h20 : 32'h0);
            do_load(v);
            check("R2 load", status_q, v);
            check("R3 round mode", {30'd0, round_mode}, 32'(m));
            check("R3 flush", {31'd0, flush_en}, 32'(m % 2));
        end
    endtask

    task automatic t_accum();
        do_load(32'h0000_0400);
        do_op("R4 inexact", 5'b00001, 1'b0, 2'd0, 5'd0, 3'd0);
        do_op("R4 invalid+overflow", 5'b10100, 1'b0, 2'd0, 5'd0, 3'd0);
        do_op("R5 no flag", 5'b00000, 1'b0, 2'd0, 5'd0, 3'd0);
        @(posedge clk); #1;
        check("R5 idle hold", status_q, exp_s);
    endtask

    task automatic t_trap();
        do_load(32'h0000_0008);
        do_op("R6 not enabled", 5'b00001, 1'b0, 2'd0, 5'd0, 3'd0);
        do_op("R6 enabled hit", 5'b01000, 1'b0, 2'd0, 5'd0, 3'd0);
        @(posedge clk); #1;
        check("R6 pulse ends", {31'd0, trap_req}, 32'd0);
        do_op("R6 already sticky", 5'b01000, 1'b0, 2'd0, 5'd0, 3'd0);
        @(posedge clk); #1;
        check("R6 pulse ends again", {31'd0, trap_req}, 32'd0);
    endtask

    task automatic t_target();
        do_load(32'h0);
        do_op("R7 R8 gt to bit21", 5'd0, 1'b1, 2'd0, 5'b10000, 3'd1);
        do_op("R7 R8 lt to bit15", 5'd0, 1'b1, 2'd1, 5'b01000, 3'd7);
        do_op("R7 R8 eq clears bit21", 5'd0, 1'b1, 2'd2, 5'b11010, 3'd1);
        do_op("R7 R8 un to bit18", 5'd0, 1'b1, 2'd3, 5'b00010, 3'd4);
        do_load(32'hFFFF_FFE0);
        do_op("R8 clear only bit19", 5'd0, 1'b1, 2'd0, 5'b01110, 3'd3);
    endtask

    task automatic t_queue();
        do_load(32'h0428_A000);
        do_op("R9 push 1", 5'd0, 1'b1, 2'd2, 5'b00100, 3'd0);
        do_op("R9 push 0", 5'd0, 1'b1, 2'd2, 5'b11010, 3'd0);
        do_op("R9 push 1 gt", 5'd0, 1'b1, 2'd0, 5'b10000, 3'd0);
        do_op("R9 push unordered 1", 5'd0, 1'b1, 2'd3, 5'b00010, 3'd0);
        do_op("R9 push 0 lt", 5'd0, 1'b1, 2'd1, 5'b10110, 3'd0);
    endtask

    task automatic t_priority();
        do_load(32'h0000_001F);
        @(negedge clk);
        load_en = 1'b1;
        load_value = 32'h0000_0013;
        op_done = 1'b1;
        op_flags = 5'b11111;
        op_is_cmp = 1'b1;
        cmp_result = 2'd0;
        cmp_cond = 5'b10000;
        cmp_target = 3'd0;
        @(posedge clk); #1;
        load_en = 1'b0;
        op_done = 1'b0;
        op_flags = '0;
        op_is_cmp = 1'b0;
        exp_s = 32'h0000_0013;
        check("R10 load wins", status_q, exp_s);
        check("R10 no trap", {31'd0, trap_req}, 32'd0);
    endtask

    task automatic t_combined();
        do_load(32'h0000_0000);
        do_op("R11 flags with push", 5'b10001, 1'b1, 2'd1, 5'b01000, 3'd0);
        do_op("R11 flags with target", 5'b00110, 1'b1, 2'd2, 5'b00100, 3'd2);
    endtask

    task automatic t_signal();
        @(negedge clk);
        cmp_cond = 5'b00001;
        #1;
        check("R12 signaling high", {31'd0, cmp_signaling}, 32'd1);
        cmp_cond = 5'b11110;
        #1;
        check("R12 signaling low", {31'd0, cmp_signaling}, 32'd0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_load_decode();
        t_accum();
        t_trap();
        t_target();
        t_queue();
        t_priority();
        t_combined();
        t_signal();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: got hung run expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule